// File: doc/BRIEF.md
# Memory-Region Hazard Scoreboard

This block lets a processor pipeline and one or more reconfigurable array units run at the same time while the units work directly on memory. Each array instruction names a function code, a source block base, a destination block base and a size exponent. Every block holds a power-of-two number of bytes and is aligned to its size. When the scoreboard accepts an instruction, it records both regions in a free entry and reports the entry index. The unit that finishes the operation hands that index back, and the entry is then released.

While an entry is busy, the scoreboard stalls any processor access that would break program order. A load stalls when it reads a pending destination. A store stalls when it writes a pending source or destination. A later array instruction stalls when it would read a pending result or overwrite a region that is still pending. Overlap is found by comparing addresses with their low bits masked off, so no range arithmetic is needed. Every unit shares the same entries, so the units are ordered against each other as well as against the processor.

The scoreboard also keeps a small cache of array contexts. It lists which function codes are loaded at the moment. An instruction whose function is not loaded is held while a context slot is refilled, and slots are reused in round-robin order.

Top module: `mem_region_sb`

## Requirements
- R1: After reset no entry is busy (busy_mask is 0), no context slot holds a function, and a processor access is not stalled.
- R2: An array instruction is accepted in a cycle where iss_valid is 1 and iss_stall is 0. It takes the lowest-numbered free entry, iss_tag shows that index in the same cycle, and the matching busy_mask bit is 1 from the next cycle on.
- R3: done_valid with done_tag equal to a busy index clears that entry from the next cycle on, and accesses to its regions then go through.
- R4: A processor load (mem_store = 0) stalls only when its address lies inside a busy destination region. A load inside a busy source region does not stall.
- R5: A processor store (mem_store = 1) stalls when its address lies inside a busy source region or a busy destination region.
- R6: A region with exponent k covers every address whose bits above bit k-1 equal those of its base. An address is therefore inside the region when the two match after the low k bits are cleared.
- R7: A new array instruction stalls when any of these holds against a busy entry: its source overlaps that entry's destination, its destination overlaps that entry's source, or its destination overlaps that entry's destination. An overlap of source with source alone does not stall. Two regions are compared by masking both with the larger of their two exponents.
- R8: While all N_ENT entries (default 4) are busy, every array instruction stalls.
- R9: The context cache holds N_CTX (default 4) function codes. An instruction whose function is cached and that has no other hazard is accepted in its first cycle. An uncached function stalls for exactly LOAD_CYC+1 cycles (default 5) and is then accepted.
- R10: Context slots are filled and then replaced in round-robin order, starting at slot 0 and wrapping after slot N_CTX-1, whatever the functions are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Array instruction presented |
| iss_func | input | FW | Function code, 0 to 13 |
| iss_src | input | AW | Source block base address |
| iss_dst | input | AW | Destination block base address |
| iss_lg | input | LGW | Block size exponent (size = 2**iss_lg) |
| iss_stall | output | 1 | Instruction held this cycle |
| iss_tag | output | IW | Entry index given to the instruction when accepted |
| mem_valid | input | 1 | Processor access presented |
| mem_store | input | 1 | 1 = store, 0 = load |
| mem_addr | input | AW | Processor access address |
| mem_stall | output | 1 | Processor access held this cycle |
| done_valid | input | 1 | An array unit finished an operation |
| done_tag | input | IW | Entry index of the finished operation |
| busy_mask | output | N_ENT | One bit per busy entry |

## Verification
The assertions rely on a few things about the inputs. done_tag always names an entry that is busy. A function code stays fixed while its instruction is stalled. Function codes 14 and 15 are never issued. The bench follows all of these: it issues only codes 1 to 5, releases only indices it was given on iss_tag, and holds every input of a stalled instruction until the stall clears. Probe instructions that test a hazard are removed before the next rising edge, so only the instructions the bench means to issue are allocated.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int unsigned ADDR_MAX = 32;

  // keep-mask for a region of size 2**lg: high bits set, low lg bits clear
  function automatic logic [ADDR_MAX-1:0] keep_mask(input logic [5:0] lg);
    logic [ADDR_MAX-1:0] m;
    m = {ADDR_MAX{1'b1}} << lg;
    return m;
  endfunction

  // address lies inside aligned region base / 2**lg
  function automatic logic in_region(input logic [ADDR_MAX-1:0] addr,
                                     input logic [ADDR_MAX-1:0] base,
                                     input logic [5:0]          lg);
    return ((addr ^ base) & keep_mask(lg)) == '0;
  endfunction

  // two aligned power-of-two regions share any address
  function automatic logic regions_meet(input logic [ADDR_MAX-1:0] a,
                                        input logic [5:0]          la,
                                        input logic [ADDR_MAX-1:0] b,
                                        input logic [5:0]          lb);
    logic [5:0] big;
    big = (la > lb) ? la : lb;
    return in_region(a, b, big);
  endfunction

endpackage

// File: rtl/sb_entry_file.sv
module sb_entry_file #(
  parameter int unsigned N   = 4,
  parameter int unsigned AW  = 16,
  parameter int unsigned LGW = 5,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_en,
  input  logic [AW-1:0]  new_src,
  input  logic [AW-1:0]  new_dst,
  input  logic [LGW-1:0] new_lg,
  input  logic           free_en,
  input  logic [IW-1:0]  free_idx,
  input  logic           acc_store,
  input  logic [AW-1:0]  acc_addr,
  output logic [IW-1:0]  alloc_idx,
  output logic           full,
  output logic           insn_hazard,
  output logic           acc_hazard,
  output logic [N-1:0]   valid_mask
);
  import sb_pkg::*;

  logic [AW-1:0]  ent_src [N];
  logic [AW-1:0]  ent_dst [N];
  logic [LGW-1:0] ent_lg  [N];
  logic [N-1:0]   ent_v;
  logic [N-1:0]   insn_hit;
  logic [N-1:0]   acc_hit;

  always_comb begin
    alloc_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_v[i]) alloc_idx = IW'(i);
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_ent
      logic raw_w, war_w, waw_w;
      assign raw_w = regions_meet(ADDR_MAX'(new_src), 6'(new_lg),
                                  ADDR_MAX'(ent_dst[g]), 6'(ent_lg[g]));
      assign war_w = regions_meet(ADDR_MAX'(new_dst), 6'(new_lg),
                                  ADDR_MAX'(ent_src[g]), 6'(ent_lg[g]));
      assign waw_w = regions_meet(ADDR_MAX'(new_dst), 6'(new_lg),
                                  ADDR_MAX'(ent_dst[g]), 6'(ent_lg[g]));
      assign insn_hit[g] = ent_v[g] & (raw_w | war_w | waw_w);
      assign acc_hit[g]  = ent_v[g] &
        (in_region(ADDR_MAX'(acc_addr), ADDR_MAX'(ent_dst[g]), 6'(ent_lg[g])) |
         (acc_store &
          in_region(ADDR_MAX'(acc_addr), ADDR_MAX'(ent_src[g]), 6'(ent_lg[g]))));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_v[g]   <= 1'b0;
          ent_src[g] <= '0;
          ent_dst[g] <= '0;
          ent_lg[g]  <= '0;
        end else if (free_en && free_idx == IW'(g)) begin
          ent_v[g] <= 1'b0;
        end else if (alloc_en && alloc_idx == IW'(g)) begin
          ent_v[g]   <= 1'b1;
          ent_src[g] <= new_src;
          ent_dst[g] <= new_dst;
          ent_lg[g]  <= new_lg;
        end
      end

      AST_ALLOC_TAKES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && alloc_idx == IW'(g)) |-> !ent_v[g]); // R2
    end
  endgenerate

  assign full        = &ent_v;
  assign insn_hazard = |insn_hit;
  assign acc_hazard  = |acc_hit;
  assign valid_mask  = ent_v;

  AST_EMPTY_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_v == '0) |-> (!acc_hazard && !insn_hazard)); // R1

endmodule

// File: rtl/sb_ctx_cache.sv
module sb_ctx_cache #(
  parameter int unsigned NCTX     = 4,
  parameter int unsigned FW       = 4,
  parameter int unsigned LOAD_CYC = 4,
  localparam int unsigned CW      = $clog2(LOAD_CYC + 1),
  localparam int unsigned PW      = $clog2(NCTX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [FW-1:0] req_func,
  output logic          hit,
  output logic          loading
);
  logic [FW-1:0]   slot_func [NCTX];
  logic [NCTX-1:0] slot_v;
  logic [NCTX-1:0] hit_vec;
  logic [PW-1:0]   rr_ptr;
  logic [CW-1:0]   cnt;
  logic [FW-1:0]   ld_func;
  logic            load_start;
  logic            load_end;

  generate
    for (genvar g = 0; g < NCTX; g++) begin : g_hit
      assign hit_vec[g] = slot_v[g] && (slot_func[g] == req_func);
    end
  endgenerate

  assign hit        = |hit_vec;
  assign load_start = req && !hit && !loading;
  assign load_end   = loading && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v  <= '0;
      rr_ptr  <= '0;
      cnt     <= '0;
      loading <= 1'b0;
      ld_func <= '0;
      for (int i = 0; i < NCTX; i++) slot_func[i] <= '0;
    end else if (load_start) begin
      loading <= 1'b1;
      cnt     <= CW'(LOAD_CYC - 1);
      ld_func <= req_func;
    end else if (load_end) begin
      loading           <= 1'b0;
      slot_func[rr_ptr] <= ld_func;
      slot_v[rr_ptr]    <= 1'b1;
      rr_ptr            <= (rr_ptr == PW'(NCTX - 1)) ? '0 : rr_ptr + 1'b1;
    end else if (loading) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_CTX_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1); // R9
  AST_LOAD_FILLS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> (slot_v[$past(rr_ptr)] && !loading)); // R10
  AST_LOAD_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loading) |-> $past(!hit)); // R9

endmodule

// File: rtl/mem_region_sb.sv
module mem_region_sb #(
  parameter int unsigned AW       = 16,
  parameter int unsigned N_ENT    = 4,
  parameter int unsigned N_CTX    = 4,
  parameter int unsigned FW       = 4,
  parameter int unsigned LOAD_CYC = 4,
  localparam int unsigned LGW     = $clog2(AW + 1),
  localparam int unsigned IW      = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [FW-1:0]    iss_func,
  input  logic [AW-1:0]    iss_src,
  input  logic [AW-1:0]    iss_dst,
  input  logic [LGW-1:0]   iss_lg,
  output logic             iss_stall,
  output logic [IW-1:0]    iss_tag,
  input  logic             mem_valid,
  input  logic             mem_store,
  input  logic [AW-1:0]    mem_addr,
  output logic             mem_stall,
  input  logic             done_valid,
  input  logic [IW-1:0]    done_tag,
  output logic [N_ENT-1:0] busy_mask
);
  logic sb_full, insn_haz, acc_haz;
  logic ctx_hit, ctx_loading;
  logic issue_fire;

  sb_entry_file #(.N(N_ENT), .AW(AW), .LGW(LGW)) ent_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (issue_fire),
    .new_src     (iss_src),
    .new_dst     (iss_dst),
    .new_lg      (iss_lg),
    .free_en     (done_valid),
    .free_idx    (done_tag),
    .acc_store   (mem_store),
    .acc_addr    (mem_addr),
    .alloc_idx   (iss_tag),
    .full        (sb_full),
    .insn_hazard (insn_haz),
    .acc_hazard  (acc_haz),
    .valid_mask  (busy_mask)
  );

  sb_ctx_cache #(.NCTX(N_CTX), .FW(FW), .LOAD_CYC(LOAD_CYC)) ctx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (iss_valid),
    .req_func (iss_func),
    .hit      (ctx_hit),
    .loading  (ctx_loading)
  );

  assign iss_stall  = iss_valid && (sb_full || insn_haz || !ctx_hit);
  assign issue_fire = iss_valid && !iss_stall;
  assign mem_stall  = mem_valid && acc_haz;

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (&busy_mask)) |-> iss_stall); // R8
  AST_FIRE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> busy_mask[$past(iss_tag)]); // R2
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !busy_mask[$past(done_tag)]); // R3
  AST_IDLE_NO_MEM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mask == '0) |-> !mem_stall); // R4
  AST_LOADING_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_loading && iss_valid) |-> iss_stall); // R9

endmodule

// File: tb/mem_region_sb_tb_top.sv
module mem_region_sb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_func = '0;
  logic [15:0] iss_src = '0, iss_dst = '0;
  logic [4:0]  iss_lg = '0;
  logic        iss_stall;
  logic [1:0]  iss_tag;
  logic        mem_valid = 1'b0, mem_store = 1'b0;
  logic [15:0] mem_addr = '0;
  logic        mem_stall;
  logic        done_valid = 1'b0;
  logic [1:0]  done_tag = '0;
  logic [3:0]  busy_mask;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mem_region_sb dut_i (.*);

  // {store, addr, expected stall} against entry src 0x1000 / dst 0x2000, exponent 8
  localparam logic [17:0] MEM_VEC [8] = '{
    {1'b0, 16'h2040, 1'b1},   // R4 load in dst
    {1'b0, 16'h1040, 1'b0},   // R4 load in src
    {1'b1, 16'h1040, 1'b1},   // R5 store in src
    {1'b1, 16'h20FF, 1'b1},   // R5 R6 top byte of dst
    {1'b1, 16'h2100, 1'b0},   // R6 just past dst
    {1'b0, 16'h1FFF, 1'b0},   // R6 just below dst
    {1'b1, 16'h0FFF, 1'b0},   // R6 just below src
    {1'b0, 16'h3000, 1'b0}    // R4 unrelated
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] f, input logic [15:0] s, input logic [15:0] d,
                       input logic [4:0] lg, output int stalls, output logic [1:0] tag);
    @(negedge clk);
    iss_valid = 1'b1; iss_func = f; iss_src = s; iss_dst = d; iss_lg = lg;
    stalls = 0;
    forever begin
      #1;
      if (!iss_stall) begin
        tag = iss_tag;
        @(posedge clk);
        break;
      end
      stalls++;
      if (stalls > 60) begin tag = '0; break; end
      @(negedge clk);
    end
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic probe(input logic [3:0] f, input logic [15:0] s, input logic [15:0] d,
                       input logic [4:0] lg, output logic st);
    @(negedge clk);
    iss_valid = 1'b1; iss_func = f; iss_src = s; iss_dst = d; iss_lg = lg;
    #1 st = iss_stall;
    #1 iss_valid = 1'b0;
  endtask

  task automatic mem_probe(input logic store, input logic [15:0] a, output logic st);
    @(negedge clk);
    mem_valid = 1'b1; mem_store = store; mem_addr = a;
    #1 st = mem_stall;
    #1 mem_valid = 1'b0;
  endtask

  task automatic release_tag(input logic [1:0] t);
    @(negedge clk);
    done_valid = 1'b1; done_tag = t;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic run_ctx(input string req, input logic [3:0] f, input logic [15:0] base,
                         input int exp_stalls);
    int st; logic [1:0] tg;
    issue(f, base, base + 16'h0100, 5'd8, st, tg);
    check(req, 32'(st), 32'(exp_stalls));
    release_tag(tg);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int st; logic [1:0] tg; logic s1;
    logic [1:0] tags [4];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 busy after reset", 32'(busy_mask), 32'h0);
    mem_probe(1'b1, 16'h2000, s1);
    check("R1 store after reset", 32'(s1), 32'h0);

    // R2 R9 first issue: function 1 uncached
    issue(4'd1, 16'h1000, 16'h2000, 5'd8, st, tg);
    check("R9 miss stall cycles", 32'(st), 32'd5);
    check("R2 first tag", 32'(tg), 32'h0);
    check("R2 busy after issue", 32'(busy_mask), 32'h1);

    // R4 R5 R6 table of processor accesses
    foreach (MEM_VEC[i]) begin
      mem_probe(MEM_VEC[i][17], MEM_VEC[i][16:1], s1);
      check($sformatf("R4 R5 R6 vector %0d", i), 32'(s1), 32'(MEM_VEC[i][0]));
    end

    // R7 instruction ordering against entry 0
    probe(4'd1, 16'h2080, 16'h5000, 5'd4, s1);
    check("R7 src over busy dst", 32'(s1), 32'h1);
    probe(4'd1, 16'h1000, 16'h6000, 5'd8, s1);
    check("R7 src over busy src", 32'(s1), 32'h0);
    probe(4'd1, 16'h7000, 16'h1010, 5'd4, s1);
    check("R7 dst over busy src", 32'(s1), 32'h1);
    probe(4'd1, 16'h7000, 16'h2000, 5'd2, s1);
    check("R7 dst over busy dst", 32'(s1), 32'h1);
    probe(4'd1, 16'h0000, 16'h8000, 5'd14, s1);
    check("R7 R6 larger exponent", 32'(s1), 32'h1);

    // R3 release
    release_tag(2'd0);
    check("R3 busy after done", 32'(busy_mask), 32'h0);
    mem_probe(1'b0, 16'h2040, s1);
    check("R3 load after done", 32'(s1), 32'h0);

    // R8 fill all entries, R2 lowest free index reuse
    for (int k = 0; k < 4; k++) begin
      issue(4'd1, 16'h4000 + 16'(k) * 16'h0200, 16'h4100 + 16'(k) * 16'h0200, 5'd8, st, tg);
      tags[k] = tg;
      check("R2 sequential tag", 32'(tg), 32'(k));
    end
    check("R8 all busy", 32'(busy_mask), 32'hF);
    probe(4'd1, 16'hC000, 16'hD000, 5'd4, s1);
    check("R8 stall when full", 32'(s1), 32'h1);
    release_tag(2'd2);
    issue(4'd1, 16'hC000, 16'hD000, 5'd4, st, tg);
    check("R2 reuse lowest free", 32'(tg), 32'd2);
    check("R2 no stall after free", 32'(st), 32'd0);
    for (int k = 0; k < 4; k++) release_tag(2'(k));
    check("R3 all released", 32'(busy_mask), 32'h0);

    // R9 R10 context cache, slot 0 holds function 1
    run_ctx("R9 fill slot1", 4'd2, 16'h0000, 5);
    run_ctx("R9 fill slot2", 4'd3, 16'h0000, 5);
    run_ctx("R9 fill slot3", 4'd4, 16'h0000, 5);
    run_ctx("R9 hit func1", 4'd1, 16'h0000, 0);
    run_ctx("R10 func5 replaces slot0", 4'd5, 16'h0000, 5);
    run_ctx("R10 func1 evicted", 4'd1, 16'h0000, 5);
    run_ctx("R10 func3 kept", 4'd3, 16'h0000, 0);
    run_ctx("R10 func2 evicted", 4'd2, 16'h0000, 5);
    run_ctx("R10 func3 evicted", 4'd3, 16'h0000, 5);
    run_ctx("R10 func5 kept", 4'd5, 16'h0000, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule